// File: doc/BRIEF.md
# Non-Maskable Interrupt Detector with Sticky Status Flag

This block sits at the entry of an interrupt controller and watches one external non-maskable interrupt pin. The pin passes through a multi-flop synchroniser. An edge detector, set by a select input to rising or falling polarity, turns the chosen transition into a one-cycle event. Each event raises a pending request toward the CPU. That request stays high until the CPU returns an acknowledge.

Each event also sets a sticky flag that software can see. The flag is read and cleared through one 32-bit status word. Software can only clear it, and only by writing 0. The same word shows the live synchronised pin level in its top bit.

The flag and the request are independent. Clearing the flag never withdraws a request. Acknowledging a request never clears the flag. When the flag sets, only a software write of 0 brings it back to 0.

Top module: `nmi_flag_ctrl`

## Requirements
- R1: Bit 31 of `reg_rdata` shows the level of `nmi_pin` after a two-stage synchroniser. A pin change appears there after the second rising clock edge. A write cannot change bit 31.
- R2: When `edge_sel` is 0, only a low-to-high transition of the synchronised pin counts as an event. When `edge_sel` is 1, only a high-to-low transition counts.
- R3: An event sets `nmi_req` and the flag (bit 16 of `reg_rdata`) on the third rising edge after the pin change.
- R4: A write with bit 16 of `reg_wdata` at 0 clears the flag on the next edge. A write with bit 16 at 1 leaves the flag unchanged.
- R5: `cpu_ack` clears `nmi_req` on the next edge. `cpu_ack` does not change the flag. The flag value has no effect on `nmi_req`.
- R6: A flag-clearing write while `nmi_req` is high and no acknowledge is present leaves `nmi_req` high.
- R7: If an event arrives in the same cycle as a flag-clearing write, the flag ends at 1.
- R8: If an event arrives in the same cycle as `cpu_ack`, `nmi_req` stays 1.
- R9: Bits 30 to 17 and 15 to 0 of `reg_rdata` always read 0, and writes do not change them. After reset, the flag and `nmi_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| nmi_pin | input | 1 | Asynchronous external interrupt pin |
| edge_sel | input | 1 | Event polarity: 0 = rising, 1 = falling |
| cpu_ack | input | 1 | CPU acknowledge, retires the pending request |
| nmi_req | output | 1 | Pending non-maskable request to the CPU |
| reg_wr_en | input | 1 | Single-cycle write strobe for the status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational status word |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, a 32-bit word, the level at bit 31 and the flag at bit 16. With a fixed synchroniser depth, the cycle in which an event is internally present is known exactly. Because of this, the bench can place a flag-clearing write or a CPU acknowledge in that same cycle and test both collision rules. The bench runs both polarities of the edge select. For each polarity it checks that the opposite transition produces nothing.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } nmi_edge_e;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = async_in;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_edge_det.sv
module nmi_edge_det
  import nmi_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      level,
  input  nmi_edge_e polarity,
  output logic      event_pulse
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  always_comb begin
    unique case (polarity)
      EDGE_RISE: event_pulse = level & ~prev_q;
      EDGE_FALL: event_pulse = ~level & prev_q;
      default:   event_pulse = 1'b0;
    endcase
  end
endmodule

// File: rtl/nmi_req_track.sv
module nmi_req_track (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic ack,
  output logic req
);
  logic req_q;
  logic req_d;
  logic req_en;

  // A new event overrides a simultaneous acknowledge.
  assign req_en = set_evt | ack;
  always_comb req_d = set_evt ? 1'b1 : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (req_en) req_q <= req_d;
  end

  assign req = req_q;
endmodule

// File: rtl/nmi_status_reg.sv
module nmi_status_reg #(
  parameter int DATA_W    = 32,
  parameter int LEVEL_BIT = 31,
  parameter int FLAG_BIT  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_evt,
  input  logic              level,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic flag_q;
  logic flag_d;
  logic flag_en;
  logic clr_req;
  logic unused_wdata;

  assign clr_req      = wr_en & ~wdata[FLAG_BIT];
  assign unused_wdata = ^wdata;

  // Hardware set has priority over a software clear in the same cycle.
  assign flag_en = set_evt | clr_req;
  always_comb flag_d = set_evt ? 1'b1 : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  always_comb begin
    rdata            = '0;
    rdata[LEVEL_BIT] = level;
    rdata[FLAG_BIT]  = flag_q;
  end
endmodule

// File: rtl/nmi_flag_ctrl.sv
module nmi_flag_ctrl
  import nmi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32,
  parameter int LEVEL_BIT   = 31,
  parameter int FLAG_BIT    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_pin,
  input  logic              edge_sel,
  input  logic              cpu_ack,
  output logic              nmi_req,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic      pin_sync;
  logic      det_pulse;
  nmi_edge_e polarity;

  assign polarity = nmi_edge_e'(edge_sel);

  nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (nmi_pin),
    .sync_out (pin_sync)
  );

  nmi_edge_det u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .level       (pin_sync),
    .polarity    (polarity),
    .event_pulse (det_pulse)
  );

  nmi_req_track u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (det_pulse),
    .ack     (cpu_ack),
    .req     (nmi_req)
  );

  nmi_status_reg #(
    .DATA_W    (DATA_W),
    .LEVEL_BIT (LEVEL_BIT),
    .FLAG_BIT  (FLAG_BIT)
  ) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (det_pulse),
    .level   (pin_sync),
    .wr_en   (reg_wr_en),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata)
  );
endmodule

// File: rtl/nmi_flag_ctrl_chk.sv
module nmi_flag_ctrl_chk #(
  parameter int DATA_W    = 32,
  parameter int LEVEL_BIT = 31,
  parameter int FLAG_BIT  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              det,
  input logic              cpu_ack,
  input logic              nmi_req,
  input logic              reg_wr_en,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata
);
  logic [DATA_W-1:0] rsvd_mask;
  logic              clr_wr;

  always_comb begin
    rsvd_mask            = '1;
    rsvd_mask[LEVEL_BIT] = 1'b0;
    rsvd_mask[FLAG_BIT]  = 1'b0;
  end
  assign clr_wr = reg_wr_en & ~reg_wdata[FLAG_BIT];

  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & rsvd_mask) == '0);

  p_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    det |=> (nmi_req && reg_rdata[FLAG_BIT]));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !det) |=> !nmi_req);

  p_ack_keeps_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[FLAG_BIT] && cpu_ack && !clr_wr) |=> reg_rdata[FLAG_BIT]);

  p_clear_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !det) |=> !reg_rdata[FLAG_BIT]);

  p_clear_keeps_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !cpu_ack && clr_wr) |=> nmi_req);

  p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (det && clr_wr) |=> reg_rdata[FLAG_BIT]);

  p_set_beats_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (det && cpu_ack) |=> nmi_req);
endmodule

bind nmi_flag_ctrl nmi_flag_ctrl_chk #(
  .DATA_W    (DATA_W),
  .LEVEL_BIT (LEVEL_BIT),
  .FLAG_BIT  (FLAG_BIT)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .det       (det_pulse),
  .cpu_ack   (cpu_ack),
  .nmi_req   (nmi_req),
  .reg_wr_en (reg_wr_en),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata)
);

// File: tb/nmi_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module nmi_flag_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        nmi_pin;
  logic        edge_sel;
  logic        cpu_ack;
  logic        nmi_req;
  logic        reg_wr_en;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int  n_tests;
  int  n_fail;
  bit  done;

  localparam logic [31:0] RSVD = 32'h7FFE_FFFF;

  nmi_flag_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_pin   (nmi_pin),
    .edge_sel  (edge_sel),
    .cpu_ack   (cpu_ack),
    .nmi_req   (nmi_req),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Changes the pin, then stops in the cycle where the event is internally
  // present (after the second rising edge). Side inputs are applied there
  // and captured by the third rising edge.
  task automatic pin_to_event(input logic v, input logic ack, input logic wr,
                              input logic [31:0] wd);
    @(negedge clk) nmi_pin = v;
    @(negedge clk);
    @(negedge clk);
    cpu_ack   = ack;
    reg_wr_en = wr;
    reg_wdata = wd;
    @(negedge clk);
    cpu_ack   = 1'b0;
    reg_wr_en = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic write_reg(input logic [31:0] wd);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wdata = wd;
    @(negedge clk);
    reg_wr_en = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic do_ack();
    @(negedge clk) cpu_ack = 1'b1;
    @(negedge clk) cpu_ack = 1'b0;
  endtask

  task automatic t_reset();
    check(reg_rdata == 32'h0, "R9 reset status", reg_rdata, 32'h0);
    check(nmi_req == 1'b0, "R9 reset req", {31'b0, nmi_req}, 32'h0);
  endtask

  task automatic t_rise_level_and_set();
    @(negedge clk) nmi_pin = 1'b1;
    @(negedge clk);
    check(reg_rdata[31] == 1'b0, "R1 level after one edge", {31'b0, reg_rdata[31]}, 0);
    @(negedge clk);
    check(reg_rdata[31] == 1'b1, "R1 level after two edges", {31'b0, reg_rdata[31]}, 1);
    check(nmi_req == 1'b0, "R3 req not yet", {31'b0, nmi_req}, 0);
    @(negedge clk);
    check(nmi_req == 1'b1, "R3 req set", {31'b0, nmi_req}, 1);
    check(reg_rdata[16] == 1'b1, "R3 flag set", {31'b0, reg_rdata[16]}, 1);
  endtask

  task automatic t_write_effects();
    write_reg(32'h0001_0000);
    check(reg_rdata[31] == 1'b1, "R1 write 0 to level bit", {31'b0, reg_rdata[31]}, 1);
    check(reg_rdata[16] == 1'b1, "R4 write 1 keeps flag", {31'b0, reg_rdata[16]}, 1);
    write_reg(32'hFFFF_FFFF);
    check((reg_rdata & RSVD) == 0, "R9 reserved after all-ones", reg_rdata & RSVD, 0);
    check(reg_rdata[16] == 1'b1, "R4 all-ones keeps flag", {31'b0, reg_rdata[16]}, 1);
  endtask

  task automatic t_ack();
    do_ack();
    check(nmi_req == 1'b0, "R5 ack clears req", {31'b0, nmi_req}, 0);
    check(reg_rdata[16] == 1'b1, "R5 ack keeps flag", {31'b0, reg_rdata[16]}, 1);
    write_reg(32'h0);
    check(reg_rdata[16] == 1'b0, "R4 write 0 clears flag", {31'b0, reg_rdata[16]}, 0);
    write_reg(32'h0001_0000);
    check(reg_rdata[16] == 1'b0, "R4 write 1 leaves flag 0", {31'b0, reg_rdata[16]}, 0);
    check(nmi_req == 1'b0, "R5 flag writes leave req", {31'b0, nmi_req}, 0);
  endtask

  task automatic t_rise_ignores_fall();
    pin_to_event(1'b0, 1'b0, 1'b0, '0);
    idle(2);
    check(nmi_req == 1'b0, "R2 rising mode ignores fall", {31'b0, nmi_req}, 0);
    check(reg_rdata[16] == 1'b0, "R2 rising mode fall no flag", {31'b0, reg_rdata[16]}, 0);
  endtask

  task automatic t_falling_mode();
    edge_sel = 1'b1;
    pin_to_event(1'b1, 1'b0, 1'b0, '0);
    idle(2);
    check(nmi_req == 1'b0, "R2 falling mode ignores rise", {31'b0, nmi_req}, 0);
    pin_to_event(1'b0, 1'b0, 1'b0, '0);
    check(nmi_req == 1'b1, "R2 falling mode fall sets req", {31'b0, nmi_req}, 1);
    check(reg_rdata[16] == 1'b1, "R2 falling mode flag", {31'b0, reg_rdata[16]}, 1);
    write_reg(32'h0);
    check(nmi_req == 1'b1, "R6 clear keeps pending req", {31'b0, nmi_req}, 1);
    check(reg_rdata[16] == 1'b0, "R6 flag cleared", {31'b0, reg_rdata[16]}, 0);
    do_ack();
    check(nmi_req == 1'b0, "R5 ack after clear", {31'b0, nmi_req}, 0);
    edge_sel = 1'b0;
    idle(2);
  endtask

  task automatic t_set_vs_clear();
    pin_to_event(1'b1, 1'b0, 1'b1, 32'h0);
    check(reg_rdata[16] == 1'b1, "R7 set beats clear", {31'b0, reg_rdata[16]}, 1);
    check(nmi_req == 1'b1, "R7 req set", {31'b0, nmi_req}, 1);
  endtask

  task automatic t_set_vs_ack();
    pin_to_event(1'b0, 1'b0, 1'b0, '0);
    idle(1);
    pin_to_event(1'b1, 1'b1, 1'b0, '0);
    check(nmi_req == 1'b1, "R8 event beats ack", {31'b0, nmi_req}, 1);
    do_ack();
    check(nmi_req == 1'b0, "R8 later ack clears", {31'b0, nmi_req}, 0);
  endtask

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; nmi_pin = 1'b0; edge_sel = 1'b0; cpu_ack = 1'b0;
    reg_wr_en = 1'b0; reg_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_rise_level_and_set();
    t_write_effects();
    t_ack();
    t_rise_ignores_fall();
    t_falling_mode();
    t_set_vs_clear();
    t_set_vs_ack();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule